// File: doc/BRIEF.md
# Reloadable Baud Tick Generator

This block derives the timing strobes of a serial port from the system clock. A software-written 8-bit divisor sets the period of a down-counting timer. Each time that timer expires, the block emits an oversample tick. A prescaler counts these oversample ticks and emits a bit tick once every 16, 64 or 4 of them. The ratio depends on a speed input and a mode input. The transmitter and receiver use the oversample tick to place samples and the bit tick to advance from one bit to the next.

Writing the divisor restarts both the timer and the prescaler at once. A new rate therefore takes effect within two cycles and does not wait for the old period to run out. In asynchronous mode the speed input chooses between 16 and 64 oversample ticks per bit. In synchronous mode the speed input is ignored and one bit spans 4 oversample ticks. The figures below apply to master operation, where the block runs from its own clock.

Top module: `baud_tick_gen`

## Requirements
- R1: While the active-low reset is held, `os_tick` and `bit_tick` are 0, and the divisor resets to 0.
- R2: With divisor X and no write, `os_tick` rises every X+1 clock cycles. For X>0 each pulse is one cycle wide.
- R3: A cycle with `div_wr`=1 loads `div_data` and restarts the timer and the prescaler. The next cycle has no tick on either output. The cycle after that has `os_tick`=1, whatever phase the old count was in.
- R4: In asynchronous mode (`sync_mode`=0) with `speed_hi`=1, a bit tick comes on every 16th oversample tick, so bit ticks are 16·(X+1) cycles apart.
- R5: In asynchronous mode with `speed_hi`=0, a bit tick comes on every 64th oversample tick, so bit ticks are 64·(X+1) cycles apart.
- R6: In synchronous mode (`sync_mode`=1), bit ticks are 4·(X+1) cycles apart and `speed_hi` has no effect on either output.
- R7: `bit_tick` is high only in a cycle where `os_tick` is also high.
- R8: The ratio follows the speed and mode inputs at each oversample tick. If the prescaler has already passed the new ratio, the next oversample tick also gives a bit tick and the count starts over.
- R9: Divisor boundaries: X=0 gives an oversample tick on every cycle. X=255 gives 256 cycles between oversample ticks.
- R10: Out of reset (X=0, `speed_hi`=0, asynchronous), bit ticks are 64 cycles apart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| div_wr | input | 1 | Divisor write strobe |
| div_data | input | 8 | Divisor value X written on `div_wr` |
| speed_hi | input | 1 | 1: 16 oversample ticks per bit, 0: 64 (asynchronous only) |
| sync_mode | input | 1 | 1: synchronous, 4 oversample ticks per bit |
| os_tick | output | 1 | Oversample tick, one per timer expiry |
| bit_tick | output | 1 | Bit-rate tick |

## Verification
The bench writes the divisor at many different phases of the running count. A design that only reloaded at expiry would show a late first tick after the write, and one that skipped clearing the prescaler would give a short first bit. It shrinks the ratio from 64 to 16 after the prescaler has already passed 15. An equality-only wrap would then run on for dozens of extra oversample ticks instead of firing at once. It also toggles the speed input in synchronous mode, where any leak of that input would change the 4·(X+1) bit period, and it runs the divisor extremes 0 and 255, where an off-by-one in the reload shows up as a wrong period.

// File: rtl/brg_pkg.sv
// Shared definitions for the baud tick generator.
// Assumes: ratios are powers of two or any value from 2 to 256.
package brg_pkg;

    // Which oversample-per-bit ratio is in force
    typedef enum logic [1:0] {
        RATE_SYNC = 2'd0,
        RATE_FAST = 2'd1,
        RATE_SLOW = 2'd2
    } rate_sel_e;

    // Largest of three ratios, used to size the prescaler
    function automatic int unsigned ratio_max(input int unsigned a,
                                              input int unsigned b,
                                              input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/brg_div_timer.sv
// Divisor register plus down-counting period timer.
// Counts X..0, reloads X, and flags the reload cycle (wrap).
// A load clears the count to zero so the next cycle wraps (R3).
// Assumes: load_en is synchronous to clk.
module brg_div_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic [DIV_W-1:0] load_val,
    output logic             wrap,
    output logic             expire
);
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] cnt_q;

    // Timer reaches zero and no load overrides it this cycle
    assign wrap = (cnt_q == '0) && !load_en;

    // Divisor register: reset to zero, replaced on a write (R1)
    always_ff @(posedge clk) begin
        if (!rst_n)       div_q <= '0;
        else if (load_en) div_q <= load_val;
    end

    // Down counter with reload, cleared by a write (R2, R3)
    always_ff @(posedge clk) begin
        if (!rst_n || load_en) cnt_q <= '0;
        else if (wrap)         cnt_q <= div_q;
        else                   cnt_q <= cnt_q - 1'b1;
    end

    // Registered expiry pulse, low during reset and after a write
    always_ff @(posedge clk) begin
        if (!rst_n) expire <= 1'b0;
        else        expire <= wrap;
    end
endmodule

// File: rtl/brg_ratio_sel.sv
// Picks the oversample-per-bit ratio from the mode and speed inputs
// and presents it as a terminal count (ratio - 1).
// Assumes: every ratio fits in 2**PRE_W.
module brg_ratio_sel
    import brg_pkg::*;
#(
    parameter int PRE_W      = 6,
    parameter int FAST_RATIO = 16,
    parameter int SLOW_RATIO = 64,
    parameter int SYNC_RATIO = 4
) (
    input  logic             speed_hi,
    input  logic             sync_mode,
    output logic [PRE_W-1:0] last_cnt
);
    localparam logic [PRE_W-1:0] FAST_LAST = PRE_W'(FAST_RATIO - 1);
    localparam logic [PRE_W-1:0] SLOW_LAST = PRE_W'(SLOW_RATIO - 1);
    localparam logic [PRE_W-1:0] SYNC_LAST = PRE_W'(SYNC_RATIO - 1);

    rate_sel_e sel;

    // Sync mode overrides the speed bit (R6)
    always_comb begin
        if (sync_mode)     sel = RATE_SYNC;
        else if (speed_hi) sel = RATE_FAST;
        else               sel = RATE_SLOW;
    end

    // Terminal count for the selected ratio (R4, R5, R6)
    always_comb begin
        unique case (sel)
            RATE_FAST: last_cnt = FAST_LAST;
            RATE_SLOW: last_cnt = SLOW_LAST;
            default:   last_cnt = SYNC_LAST;
        endcase
    end
endmodule

// File: rtl/brg_prescaler.sv
// Counts timer wraps and pulses once per ratio. Wraps on a
// greater-or-equal compare so a ratio cut mid-count recovers at once.
// Assumes: step and clear are never both needed (clear wins).
module brg_prescaler #(
    parameter int PRE_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    input  logic [PRE_W-1:0] last_cnt,
    output logic             pulse
);
    logic [PRE_W-1:0] pre_q;
    logic             at_end;

    // Count has met or passed the current terminal value (R8)
    assign at_end = (pre_q >= last_cnt);

    // Wrap counter, cleared on reset or divisor write (R3)
    always_ff @(posedge clk) begin
        if (!rst_n || clear) pre_q <= '0;
        else if (step)       pre_q <= at_end ? '0 : pre_q + 1'b1;
    end

    // Bit pulse only on a step, so it rides an oversample tick (R7)
    always_ff @(posedge clk) begin
        if (!rst_n || clear) pulse <= 1'b0;
        else                 pulse <= step && at_end;
    end
endmodule

// File: rtl/baud_tick_gen.sv
// Baud tick generator top: divisor timer, ratio selection and prescaler.
// Produces an oversample tick every X+1 cycles and a bit tick every
// 16, 64 or 4 oversample ticks. Assumes all inputs are synchronous.
module baud_tick_gen
    import brg_pkg::*;
#(
    parameter int DIV_W      = 8,
    parameter int FAST_RATIO = 16,
    parameter int SLOW_RATIO = 64,
    parameter int SYNC_RATIO = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             div_wr,
    input  logic [DIV_W-1:0] div_data,
    input  logic             speed_hi,
    input  logic             sync_mode,
    output logic             os_tick,
    output logic             bit_tick
);
    localparam int MAX_RATIO = ratio_max(FAST_RATIO, SLOW_RATIO, SYNC_RATIO);
    localparam int PRE_W     = (MAX_RATIO > 2) ? $clog2(MAX_RATIO) : 1;

    logic             wrap;
    logic [PRE_W-1:0] last_cnt;

    brg_div_timer #(.DIV_W(DIV_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (div_wr),
        .load_val (div_data),
        .wrap     (wrap),
        .expire   (os_tick)
    );

    brg_ratio_sel #(
        .PRE_W      (PRE_W),
        .FAST_RATIO (FAST_RATIO),
        .SLOW_RATIO (SLOW_RATIO),
        .SYNC_RATIO (SYNC_RATIO)
    ) u_ratio (
        .speed_hi  (speed_hi),
        .sync_mode (sync_mode),
        .last_cnt  (last_cnt)
    );

    brg_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (div_wr),
        .step     (wrap),
        .last_cnt (last_cnt),
        .pulse    (bit_tick)
    );
endmodule

// File: rtl/baud_tick_gen_chk.sv
// Port-level checker for baud_tick_gen, attached by bind below.
// Keeps its own copy of the divisor and a gap counter.
module baud_tick_gen_chk #(
    parameter int DIV_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             div_wr,
    input logic [DIV_W-1:0] div_data,
    input logic             os_tick,
    input logic             bit_tick
);
    logic [DIV_W-1:0] shadow;
    logic [DIV_W+1:0] gap;
    logic             armed;

    // Track divisor and the cycles since the last oversample tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow <= '0; gap <= '0; armed <= 1'b0;
        end else if (div_wr) begin
            shadow <= div_data; gap <= '0; armed <= 1'b0;
        end else if (os_tick) begin
            gap <= 1; armed <= 1'b1;
        end else begin
            gap <= gap + 1'b1;
        end
    end

    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (!os_tick && !bit_tick));

    p_os_period_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && os_tick) |-> (gap == {2'b00, shadow} + 1'b1));

    p_write_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        div_wr |=> (!os_tick && !bit_tick));

    p_first_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!div_wr && $past(div_wr)) |=> os_tick);

    p_bit_on_os_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |-> os_tick);
endmodule

bind baud_tick_gen baud_tick_gen_chk #(.DIV_W(DIV_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .div_wr   (div_wr),
    .div_data (div_data),
    .os_tick  (os_tick),
    .bit_tick (bit_tick)
);

// File: tb/sim_baud_tick_gen.sv
// Bench: behavioural reference compared on every cycle, plus directed
// period measurements. Inputs change on the falling edge.
module sim_baud_tick_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       div_wr = 1'b0;
    logic [7:0] div_data = '0;
    logic       speed_hi = 1'b0;
    logic       sync_mode = 1'b0;
    logic       os_tick, bit_tick;

    always #2 clk = ~clk;   // 250 MHz

    baud_tick_gen u0 (
        .clk(clk), .rst_n(rst_n), .div_wr(div_wr), .div_data(div_data),
        .speed_hi(speed_hi), .sync_mode(sync_mode),
        .os_tick(os_tick), .bit_tick(bit_tick)
    );

    int    n_chk = 0, n_fail = 0;
    bit    done = 0;
    string cur_req = "R1";

    // Reference: cycles left to expiry and oversample ticks seen per bit
    int   m_div = 0, m_left = 0, m_seen = 0;
    logic exp_os = 1'b0, exp_bit = 1'b0;

    always @(posedge clk) begin
        int ratio;
        ratio = sync_mode ? 4 : (speed_hi ? 16 : 64);
        if (!rst_n) begin
            m_div = 0; m_left = 0; m_seen = 0; exp_os = 0; exp_bit = 0;
        end else if (div_wr) begin
            m_div = div_data; m_left = 0; m_seen = 0; exp_os = 0; exp_bit = 0;
        end else if (m_left == 0) begin
            exp_os = 1; m_left = m_div;
            m_seen = m_seen + 1;
            if (m_seen >= ratio) begin exp_bit = 1; m_seen = 0; end
            else exp_bit = 0;
        end else begin
            m_left = m_left - 1; exp_os = 0; exp_bit = 0;
        end
    end

    task automatic check(input string req, input bit ok, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    // Per-cycle comparison against the reference, and the R7 relation
    always @(negedge clk) begin
        if (!done) begin
            check(cur_req, {os_tick, bit_tick} === {exp_os, exp_bit},
                  {os_tick, bit_tick}, {exp_os, exp_bit});
            check("R7", !(bit_tick && !os_tick), {os_tick, bit_tick}, 2'b10);
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_div(input int v);
        div_wr = 1'b1; div_data = 8'(v);
        @(negedge clk);
        div_wr = 1'b0;
        check("R3", os_tick === 1'b0 && bit_tick === 1'b0, os_tick, 0);
        @(negedge clk);
        check("R3", os_tick === 1'b1, os_tick, 1);
    endtask

    // Cycles between two successive bit ticks
    task automatic bit_period(input string req, input int expv);
        int n = 0;
        while (bit_tick !== 1'b1 && n < 20000) begin @(negedge clk); n++; end
        n = 0;
        do begin @(negedge clk); n++; end while (bit_tick !== 1'b1 && n < 20000);
        check(req, n == expv, n, expv);
    endtask

    task automatic os_period(input string req, input int expv);
        int n = 0;
        while (os_tick !== 1'b1 && n < 1000) begin @(negedge clk); n++; end
        n = 0;
        do begin @(negedge clk); n++; end while (os_tick !== 1'b1 && n < 1000);
        check(req, n == expv, n, expv);
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        @(negedge clk);
        cur_req = "R1";
        idle(4);
        check("R1", os_tick === 1'b0 && bit_tick === 1'b0, {os_tick, bit_tick}, 0);
        rst_n = 1'b1;

        cur_req = "R10";
        bit_period("R10", 64);
        os_period("R9", 1);

        cur_req = "R4";
        speed_hi = 1'b1;
        write_div(5);
        os_period("R2", 6);
        bit_period("R4", 96);

        cur_req = "R5";
        speed_hi = 1'b0;
        write_div(3);
        bit_period("R5", 256);

        cur_req = "R6";
        sync_mode = 1'b1; speed_hi = 1'b1;
        write_div(7);
        bit_period("R6", 32);
        speed_hi = 1'b0;
        bit_period("R6", 32);
        for (int i = 0; i < 60; i++) begin
            speed_hi = ~speed_hi;
            idle(3 + (i % 5));
        end
        sync_mode = 1'b0;

        cur_req = "R9";
        speed_hi = 1'b1;
        write_div(255);
        os_period("R9", 256);
        write_div(0);
        os_period("R9", 1);
        bit_period("R9", 16);

        cur_req = "R3";
        for (int i = 0; i < 12; i++) begin
            write_div(9);
            idle(i * 3 + 1);
        end
        write_div(4);
        bit_period("R3", 80);

        cur_req = "R8";
        speed_hi = 1'b0;
        write_div(1);
        idle(80);
        speed_hi = 1'b1;
        begin
            int n = 0;
            bit seen = 0;
            for (int k = 0; k < 3; k++) begin
                @(negedge clk);
                if (bit_tick === 1'b1) seen = 1;
            end
            n = seen;
            check("R8", seen, n, 1);
        end
        bit_period("R8", 32);

        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end
endmodule